// File: doc/BRIEF.md
# Two-Wire Serial Pattern Channel

This block drives a bit pattern out on two lines: a generated clock and a data line. Before a run, the surrounding logic presents a seed of up to 64 bits, a length code, a repeat code, a divider value, a polarity bit and two idle-level bits. It then raises the enable input. The channel copies the timing and pattern settings on the clock edge where it first sees enable high, and it ignores changes to them while it is running. The settings are the length code, repeat code, seed, divider and polarity.

The generated clock is derived from the system clock by a programmable divider. Each data bit takes one full period of the generated clock. Data moves to the next bit on the edge that the polarity bit selects. The pattern is repeated back to back. When the final bit of the final repetition is complete, the channel pulses done for one cycle and drives both lines to their idle levels. It stays in that state until enable is cleared. The channel has no streaming data interface. Every input is a plain configuration or control level, and done is a plain pulse, so there is no back-pressure.

Top module: `twowire_pattern_chan`

## Requirements
- R1: While reset is asserted, done_o is 0, sclk_o equals idle_clk_i and sdat_o equals idle_dat_i.
- R2: While enable_i is low, sclk_o follows idle_clk_i and sdat_o follows idle_dat_i, and each line follows its own idle bit independently of the other.
- R3: While running, the generated clock toggles once every div_i+1 system clock cycles, so div_i = 0 toggles it on every cycle.
- R4: Bits are sent least significant first, from seed_i bit 0 through seed_i bit len_m1_i. Bit 63 is the last bit of the upper 32-bit half. One pattern is len_m1_i+1 bits (1 to 64).
- R5: The pattern is sent reps_m1_i+1 times back to back (1 to 1024), with no gap between repetitions.
- R6: With polarity_i = 0, the clock starts low and data changes only when the clock falls. With polarity_i = 1, the clock starts high and data changes only when it rises.
- R7: done_o is high for exactly one cycle. That cycle begins 2*(div+1)*(len+1)*(reps+1) cycles after the clock edge that first samples enable_i high.
- R8: After done, the channel emits nothing further and stays idle with enable_i still high. A new run needs enable_i to go low and then high again.
- R9: When enable_i is cleared during a run, both lines return to their idle levels on the next edge, and no done pulse is produced for that run.
- R10: While enabled, changes to seed_i, len_m1_i, reps_m1_i, div_i and polarity_i have no effect on the run in progress.
- R11: From the cycle done_o rises, both lines sit at their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run request; clearing it aborts or re-arms |
| seed_i | input | 64 | Pattern bits, sent from bit 0 upward |
| len_m1_i | input | 6 | Pattern length minus one |
| reps_m1_i | input | 10 | Repetition count minus one |
| div_i | input | 32 | Half-period of the generated clock, minus one, in system cycles |
| polarity_i | input | 1 | 0: data changes on falling clock; 1: on rising clock |
| idle_clk_i | input | 1 | Level of sclk_o when not sending |
| idle_dat_i | input | 1 | Level of sdat_o when not sending |
| sclk_o | output | 1 | Generated clock |
| sdat_o | output | 1 | Serial data |
| done_o | output | 1 | One-cycle pulse after the last bit |

## Verification
Counting from the edge that first samples enable high, the lines show run cycle 0 right after that edge. The cycle-k value is clock phase floor(k/(div+1)) and data bit floor(k/(2*(div+1))) mod (len+1). The done pulse shows after edge T = 2*(div+1)*(len+1)*(reps+1) and has cleared one edge later. An enable drop shows idle levels after the next edge. The bench drives every input just after a falling clock edge and samples just after the next one. Its model therefore indexes cycle k directly, with no offset to guess, and it checks every cycle of each run against that formula.

// File: rtl/pg_pkg.sv
package pg_pkg;

  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_RUN  = 2'd1,
    PG_DONE = 2'd2
  } pg_state_e;

endpackage

// File: rtl/pg_cfg_hold.sv
module pg_cfg_hold #(
  parameter int SEED_W = 64,
  parameter int REP_W  = 10,
  parameter int DIV_W  = 32,
  parameter int LEN_W  = $clog2(SEED_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [REP_W-1:0]  rep_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              pol_i,
  output logic [SEED_W-1:0] seed_q,
  output logic [LEN_W-1:0]  len_q,
  output logic [REP_W-1:0]  rep_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              pol_q
);

  // Shadow copy follows the inputs until the channel leaves idle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q <= '0;
      len_q  <= '0;
      rep_q  <= '0;
      div_q  <= '0;
      pol_q  <= 1'b0;
    end else if (load_i) begin
      seed_q <= seed_i;
      len_q  <= len_i;
      rep_q  <= rep_i;
      div_q  <= div_i;
      pol_q  <= pol_i;
    end
  end

endmodule

// File: rtl/pg_half_timer.sv
module pg_half_timer #(
  parameter int DIV_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] limit_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = (cnt_q == limit_i);
  assign tick_o   = run_i && at_limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || at_limit) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pg_bit_seq.sv
module pg_bit_seq #(
  parameter int SEED_W = 64,
  parameter int REP_W  = 10,
  parameter int LEN_W  = $clog2(SEED_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              step_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [REP_W-1:0]  rep_i,
  output logic              bit_o,
  output logic              last_o
);

  logic [LEN_W-1:0] idx_q;
  logic [REP_W-1:0] pass_q;
  logic             end_of_pass;

  assign end_of_pass = (idx_q == len_i);
  assign last_o      = end_of_pass && (pass_q == rep_i);
  assign bit_o       = seed_i[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      pass_q <= '0;
    end else if (!run_i) begin
      idx_q  <= '0;
      pass_q <= '0;
    end else if (step_i) begin
      if (end_of_pass) begin
        idx_q  <= '0;
        pass_q <= pass_q + 1'b1;
      end else begin
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/twowire_pattern_chan.sv
module twowire_pattern_chan
  import pg_pkg::*;
#(
  parameter int SEED_W = 64,
  parameter int REP_W  = 10,
  parameter int DIV_W  = 32,
  localparam int LEN_W = $clog2(SEED_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  input  logic [REP_W-1:0]  reps_m1_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              polarity_i,
  input  logic              idle_clk_i,
  input  logic              idle_dat_i,
  output logic              sclk_o,
  output logic              sdat_o,
  output logic              done_o
);

  pg_state_e         state_q, state_d;
  logic              running, locked;
  logic [SEED_W-1:0] seed_q;
  logic [LEN_W-1:0]  len_q;
  logic [REP_W-1:0]  rep_q;
  logic [DIV_W-1:0]  div_q;
  logic              pol_q;
  logic              tick, step, final_step, last, cur_bit;
  logic              clk_q, done_q;

  assign running = (state_q == PG_RUN);
  assign locked  = (state_q != PG_IDLE);

  pg_cfg_hold #(
    .SEED_W(SEED_W), .REP_W(REP_W), .DIV_W(DIV_W), .LEN_W(LEN_W)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (!locked),
    .seed_i (seed_i),
    .len_i  (len_m1_i),
    .rep_i  (reps_m1_i),
    .div_i  (div_i),
    .pol_i  (polarity_i),
    .seed_q (seed_q),
    .len_q  (len_q),
    .rep_q  (rep_q),
    .div_q  (div_q),
    .pol_q  (pol_q)
  );

  pg_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (running),
    .limit_i (div_q),
    .tick_o  (tick)
  );

  // A toggle that returns the clock to its polarity level closes a bit.
  assign step       = tick && (clk_q != pol_q);
  assign final_step = step && last;

  pg_bit_seq #(
    .SEED_W(SEED_W), .REP_W(REP_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (running),
    .step_i (step),
    .seed_i (seed_q),
    .len_i  (len_q),
    .rep_i  (rep_q),
    .bit_o  (cur_bit),
    .last_o (last)
  );

  always_comb begin
    state_d = state_q;
    if (!enable_i) begin
      state_d = PG_IDLE;
    end else begin
      unique case (state_q)
        PG_IDLE: state_d = PG_RUN;
        PG_RUN:  if (final_step) state_d = PG_DONE;
        PG_DONE: state_d = PG_DONE;
        default: state_d = PG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PG_IDLE;
      clk_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= enable_i && final_step;
      if (!locked) begin
        clk_q <= polarity_i;
      end else if (tick) begin
        clk_q <= ~clk_q;
      end
    end
  end

  assign sclk_o = running ? clk_q   : idle_clk_i;
  assign sdat_o = running ? cur_bit : idle_dat_i;
  assign done_o = done_q;

endmodule

// File: rtl/pg_chan_checker.sv
module pg_chan_checker #(
  parameter int SEED_W = 64,
  parameter int REP_W  = 10,
  parameter int DIV_W  = 32,
  localparam int LEN_W = $clog2(SEED_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              idle_clk_i,
  input logic              idle_dat_i,
  input logic              sclk_o,
  input logic              sdat_o,
  input logic              done_o,
  input logic              running_i,
  input logic              locked_i,
  input logic              pol_q_i,
  input logic [SEED_W-1:0] seed_q_i,
  input logic [LEN_W-1:0]  len_q_i,
  input logic [REP_W-1:0]  rep_q_i,
  input logic [DIV_W-1:0]  div_q_i
);

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R7

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sclk_o == idle_clk_i && sdat_o == idle_dat_i));  // R11

  AST_NO_DONE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(enable_i));  // R9

  AST_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (sclk_o == idle_clk_i && sdat_o == idle_dat_i));  // R2

  AST_DATA_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_i && $past(running_i) && !$stable(sdat_o))
      |-> (!$stable(sclk_o) && sclk_o == pol_q_i));  // R6

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |=> ($stable(seed_q_i) && $stable(len_q_i) && $stable(rep_q_i)
                  && $stable(div_q_i) && $stable(pol_q_i)));  // R10

endmodule

bind twowire_pattern_chan pg_chan_checker #(
  .SEED_W(SEED_W), .REP_W(REP_W), .DIV_W(DIV_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .idle_clk_i (idle_clk_i),
  .idle_dat_i (idle_dat_i),
  .sclk_o     (sclk_o),
  .sdat_o     (sdat_o),
  .done_o     (done_o),
  .running_i  (running),
  .locked_i   (locked),
  .pol_q_i    (pol_q),
  .seed_q_i   (seed_q),
  .len_q_i    (len_q),
  .rep_q_i    (rep_q),
  .div_q_i    (div_q)
);

// File: tb/tb_twowire_pattern_chan.sv
module tb_twowire_pattern_chan;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic [63:0] seed_i = '0;
  logic [5:0]  len_m1_i = '0;
  logic [9:0]  reps_m1_i = '0;
  logic [31:0] div_i = '0;
  logic        polarity_i = 1'b0;
  logic        idle_clk_i = 1'b0;
  logic        idle_dat_i = 1'b0;
  logic        sclk_o, sdat_o, done_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  twowire_pattern_chan dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .seed_i(seed_i),
    .len_m1_i(len_m1_i), .reps_m1_i(reps_m1_i), .div_i(div_i),
    .polarity_i(polarity_i), .idle_clk_i(idle_clk_i), .idle_dat_i(idle_dat_i),
    .sclk_o(sclk_o), .sdat_o(sdat_o), .done_o(done_o)
  );

  typedef struct packed {
    logic [31:0] div;
    logic [5:0]  len;
    logic [9:0]  reps;
    logic [63:0] seed;
    logic        pol;
    logic        ic;
    logic        id;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'd0, 6'd7,  10'd0, 64'h0000_0000_0000_00A5, 1'b0, 1'b0, 1'b0},
    '{32'd1, 6'd3,  10'd1, 64'h0000_0000_0000_000C, 1'b1, 1'b1, 1'b0},
    '{32'd2, 6'd0,  10'd2, 64'h0000_0000_0000_0001, 1'b0, 1'b0, 1'b1},
    '{32'd0, 6'd63, 10'd0, 64'hF00D_1234_8421_C3A5, 1'b1, 1'b1, 1'b1},
    '{32'd3, 6'd5,  10'd3, 64'h0000_0000_0000_002D, 1'b0, 1'b1, 1'b1},
    '{32'd0, 6'd32, 10'd1, 64'h0000_0001_0000_0001, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic drive_cfg(input vec_t v);
    seed_i = v.seed; len_m1_i = v.len; reps_m1_i = v.reps;
    div_i = v.div; polarity_i = v.pol; idle_clk_i = v.ic; idle_dat_i = v.id;
  endtask

  // Runs one pattern to completion, scrambling the settings mid-run.
  task automatic run_vec(input vec_t v);
    int total, clk_err, dat_err, half, bidx, hold_err, dn_err;
    logic eclk, edat;
    total = 2 * (int'(v.div) + 1) * (int'(v.len) + 1) * (int'(v.reps) + 1);
    clk_err = 0; dat_err = 0; hold_err = 0; dn_err = 0;
    @(negedge clk_i);
    enable_i = 1'b0;
    drive_cfg(v);
    @(negedge clk_i);
    enable_i = 1'b1;
    for (int k = 0; k < total; k++) begin
      @(negedge clk_i);
      half = k / (int'(v.div) + 1);
      bidx = (half / 2) % (int'(v.len) + 1);
      eclk = (half % 2 == 0) ? v.pol : ~v.pol;
      edat = v.seed[bidx];
      if (sclk_o !== eclk) clk_err++;
      if (sdat_o !== edat) dat_err++;
      if (done_o !== 1'b0) dn_err++;
      if (k == 2) begin  // R10: altered settings must not reach the run
        seed_i = ~v.seed; len_m1_i = v.len + 6'd3; reps_m1_i = v.reps + 10'd2;
        div_i = v.div + 32'd5; polarity_i = ~v.pol;
      end
    end
    chk("R3 R6 R10 clock waveform mismatches", clk_err, 0);
    chk("R4 R5 R10 data waveform mismatches", dat_err, 0);
    chk("R7 early done", dn_err, 0);
    @(negedge clk_i);
    chk("R7 done at cycle T", done_o, 1'b1);
    chk("R11 lines idle at done", {sclk_o, sdat_o}, {v.ic, v.id});
    @(negedge clk_i);
    chk("R7 done one cycle", done_o, 1'b0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      if (done_o !== 1'b0 || sclk_o !== v.ic || sdat_o !== v.id) hold_err++;
    end
    chk("R8 stays idle after done", hold_err, 0);
    enable_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    vec_t w;
    int bad;
    // R1: reset state
    idle_clk_i = 1'b1; idle_dat_i = 1'b0; enable_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1 reset done", done_o, 1'b0);
    chk("R1 reset lines", {sclk_o, sdat_o}, 2'b10);
    enable_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R2: idle levels track their own bits while disabled
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      idle_clk_i = i[0]; idle_dat_i = i[1];
      @(negedge clk_i);
      chk("R2 disabled lines", {sclk_o, sdat_o}, {i[0], i[1]});
    end

    // Table walk
    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R5 boundary: maximum repeat count
    w = '{32'd0, 6'd0, 10'd1023, 64'h1, 1'b0, 1'b0, 1'b1};
    run_vec(w);

    // R9: abort mid-run, no done afterwards
    w = '{32'd1, 6'd7, 10'd3, 64'h0000_0000_0000_0096, 1'b1, 1'b0, 1'b1};
    @(negedge clk_i);
    drive_cfg(w);
    @(negedge clk_i);
    enable_i = 1'b1;
    repeat (11) @(negedge clk_i);
    enable_i = 1'b0;
    @(negedge clk_i);
    chk("R9 lines idle after abort", {sclk_o, sdat_o}, 2'b01);
    bad = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk_i);
      if (done_o !== 1'b0) bad++;
    end
    chk("R9 no done after abort", bad, 0);

    // R8: a fresh enable after abort starts a complete new run
    run_vec(VECS[0]);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule